// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Outcome History

The block keeps a small direct-mapped table of recently taken branches. Each slot stores a valid bit, an address tag, a predicted target and a two-bit history state. A fetch stage presents an instruction address on the lookup port and gets three combinational answers: whether the address is in the table, whether the branch is predicted taken, and the target to redirect to. When a branch resolves later, its address, its real outcome and its real target arrive on the update port. The table changes on the next rising clock edge.

A slot is only created when a branch that is not in the table resolves taken. A new slot starts in the strongest taken state. A branch that was never taken therefore never occupies a slot, and a miss always means "not taken". For a branch that is already present, the history state moves one step per resolved outcome, and it saturates at both ends. The four states are:

- `CTR_STRONG_NT` (0) and `CTR_WEAK_NT` (1), which predict not taken.
- `CTR_WEAK_T` (2) and `CTR_STRONG_T` (3), which predict taken.

The named transitions are:

- *climb*: one step up on a taken outcome (0→1, 1→2, 2→3).
- *hold-high*: taken while in 3, the state stays at 3.
- *descend*: one step down on a not-taken outcome (3→2, 2→1, 1→0).
- *hold-low*: not taken while in 0, the state stays at 0.
- *allocate*: a taken outcome that misses the table goes straight to 3.

Top module: `btb_predictor`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) invalidates every slot. After reset, every lookup misses.
- R2: A lookup that misses drives `lk_hit`=0, `lk_taken`=0 and `lk_target`=0.
- R3: An update with `up_taken`=1 that misses the table writes the indexed slot on the next edge. The slot becomes valid, takes the new tag and `up_target`, and starts in state 3, so the address then looks up as a taken hit.
- R4: An update with `up_taken`=0 that misses the table changes nothing. A later lookup of that address still misses.
- R5: A hitting lookup predicts taken exactly when the slot state is 2 or 3, and not taken when it is 0 or 1.
- R6: An update that hits moves the state up by one on taken and down by one on not taken. The state saturates at 3 and at 0.
- R7: From state 3, two consecutive not-taken outcomes are needed before the lookup predicts not taken.
- R8: From state 0, two consecutive taken outcomes are needed before the lookup predicts taken.
- R9: Every update that hits also overwrites the stored target with `up_target`.
- R10: The slot index is address bits [OFS_W+IDX_W-1:OFS_W] (bits [5:2] with the defaults), and the tag is every address bit above that. A taken update whose tag differs replaces the resident branch in that slot. A not-taken update whose tag differs leaves the resident branch untouched.
- R11: A lookup in the same cycle as an update to the same slot sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Fetch address to look up |
| lk_hit | output | 1 | The address is present in the table |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | ADDR_W | Predicted target; zero on a miss |
| up_en | input | 1 | A resolved branch is presented this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome: 1 for taken |
| up_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
The bench walks one branch through the whole state range:

- **Allocation.** A first not-taken outcome must not allocate. A design that allocated anyway would report a hit.
- **Walking down from 3.** The branch is driven down from 3 to past 0. A design that allocated in a weak state, or flipped after one outcome, would mispredict one step early.
- **Walking up from 0.** The branch is driven back up past 3. A counter that wrapped instead of saturating would show a not-taken prediction where taken is expected, or the reverse.
- **Aliasing.** Another address that shares the slot checks the tag rules in both directions: a not-taken alias must not disturb the resident branch, and a taken alias must replace it.
- **Remaining corners.** The bench also checks the target rewrite on every hit, a lookup that collides with an update in the same cycle (it must return the old contents), and a reset in the middle of a run that must empty the table.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Two-bit outcome history held by each table slot
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_state_e;

endpackage

// File: rtl/btb_ctr_next.sv
module btb_ctr_next
    import btb_pkg::*;
(
    input  ctr_state_e cur,
    input  logic       taken,
    output ctr_state_e nxt
);

    // Saturating one-step walk (climb / hold-high / descend / hold-low)
    always_comb begin
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_STRONG_NT;
        endcase
    end

endmodule

// File: rtl/btb_ctr_decode.sv
module btb_ctr_decode
    import btb_pkg::*;
(
    input  ctr_state_e cur,
    output logic       predict_taken
);

    always_comb begin
        unique case (cur)
            CTR_STRONG_NT, CTR_WEAK_NT: predict_taken = 1'b0;
            CTR_WEAK_T, CTR_STRONG_T:   predict_taken = 1'b1;
            default:                    predict_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int OFS_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    // read port (lookup)
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output ctr_state_e        rd_state,
    output logic [ADDR_W-1:0] rd_target,
    // write port (update)
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_target,
    input  ctr_state_e        wr_next_state,
    output logic              wr_hit,
    output ctr_state_e        wr_state
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    logic [ADDR_W-1:0]  target_q [ENTRIES];
    ctr_state_e         state_q  [ENTRIES];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             unused_ofs;

    assign rd_idx     = rd_addr[OFS_W+IDX_W-1:OFS_W];
    assign rd_tag     = rd_addr[ADDR_W-1:OFS_W+IDX_W];
    assign wr_idx     = wr_addr[OFS_W+IDX_W-1:OFS_W];
    assign wr_tag     = wr_addr[ADDR_W-1:OFS_W+IDX_W];
    assign unused_ofs = ^{rd_addr[OFS_W-1:0], wr_addr[OFS_W-1:0]};

    // read ports observe registered contents only (old data on collision)
    assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_state  = state_q[rd_idx];
    assign rd_target = target_q[rd_idx];
    assign wr_hit    = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
    assign wr_state  = state_q[wr_idx];

    logic do_step, do_alloc;
    assign do_step  = wr_en && wr_hit;
    assign do_alloc = wr_en && !wr_hit && wr_taken;

    // valid bits: the only reset state
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (do_alloc) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // payload: tag, target, history
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
            always_ff @(posedge clk) begin
                if (wr_idx == IDX_W'(e)) begin
                    if (do_step) begin
                        state_q[e]  <= wr_next_state;
                        target_q[e] <= wr_target;
                    end else if (do_alloc) begin
                        state_q[e]  <= CTR_STRONG_T;
                        tag_q[e]    <= wr_tag;
                        target_q[e] <= wr_target;
                    end
                end
            end
        end
    endgenerate

    // R1: reset leaves every slot invalid
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (valid_q == '0));

    // R4: a not-taken miss allocates nothing
    a_r4_no_alloc_nt: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && !wr_hit) |=> $stable(valid_q));

    // R3: a taken miss produces a valid slot in state 3
    a_r3_alloc_strong: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && !wr_hit) |=>
            (valid_q[$past(wr_idx)] && state_q[$past(wr_idx)] == CTR_STRONG_T));

    // R6: a hitting update moves the history by at most one step
    a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hit) |=>
            ((int'(state_q[$past(wr_idx)]) - int'($past(wr_state)) <= 1) &&
             (int'($past(wr_state)) - int'(state_q[$past(wr_idx)]) <= 1)));

    // R9: a hitting update leaves its target in the slot
    a_r9_target_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hit) |=> (target_q[$past(wr_idx)] == $past(wr_target)));

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int OFS_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_en,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);

    logic              rd_hit, wr_hit, rd_pred;
    ctr_state_e        rd_state, wr_state, wr_next;
    logic [ADDR_W-1:0] rd_target;

    btb_table #(
        .ADDR_W (ADDR_W),
        .ENTRIES(ENTRIES),
        .OFS_W  (OFS_W)
    ) u_table (
        .clk          (clk),
        .rst          (rst),
        .rd_addr      (lk_addr),
        .rd_hit       (rd_hit),
        .rd_state     (rd_state),
        .rd_target    (rd_target),
        .wr_en        (up_en),
        .wr_addr      (up_addr),
        .wr_taken     (up_taken),
        .wr_target    (up_target),
        .wr_next_state(wr_next),
        .wr_hit       (wr_hit),
        .wr_state     (wr_state)
    );

    btb_ctr_next u_next (
        .cur  (wr_state),
        .taken(up_taken),
        .nxt  (wr_next)
    );

    btb_ctr_decode u_decode (
        .cur          (rd_state),
        .predict_taken(rd_pred)
    );

    always_comb begin
        lk_hit    = rd_hit;
        lk_taken  = rd_hit && rd_pred;
        lk_target = rd_hit ? rd_target : '0;
    end

    // R2: a miss is silent
    a_r2_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (!lk_taken && lk_target == '0));

    // R5: taken is only ever predicted for a present branch
    a_r5_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
        lk_taken |-> lk_hit);

endmodule

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit, lk_taken;
    logic [AW-1:0] lk_target;
    logic          up_en = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic          up_taken = 1'b0;
    logic [AW-1:0] up_target = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;  // 50 MHz

    btb_predictor #(.ADDR_W(AW), .ENTRIES(16), .OFS_W(2)) dut (
        .clk(clk), .rst(rst),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .up_en(up_en), .up_addr(up_addr), .up_taken(up_taken), .up_target(up_target)
    );

    // slot 1 holds A or B (same index bits [5:2], different tags); C is slot 2
    localparam logic [AW-1:0] A = 32'h0000_1004;
    localparam logic [AW-1:0] B = 32'h0000_2004;
    localparam logic [AW-1:0] C = 32'h0000_1008;

    typedef struct packed {
        logic [7:0]    req;
        logic          en;
        logic [AW-1:0] addr;
        logic          tk;
        logic [AW-1:0] tgt;
        logic [AW-1:0] lk;
        logic          e_hit;
        logic          e_tk;
        logic [AW-1:0] e_tgt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'd4,  1'b1, A, 1'b0, 32'h111, A, 1'b0, 1'b0, 32'h0},   // R4 NT miss: no slot
        '{8'd3,  1'b1, A, 1'b1, 32'h200, A, 1'b1, 1'b1, 32'h200}, // R3 alloc -> 3
        '{8'd7,  1'b1, A, 1'b0, 32'h204, A, 1'b1, 1'b1, 32'h204}, // R7 3->2 still taken
        '{8'd7,  1'b1, A, 1'b0, 32'h208, A, 1'b1, 1'b0, 32'h208}, // R7 2->1 now NT
        '{8'd5,  1'b1, A, 1'b0, 32'h20C, A, 1'b1, 1'b0, 32'h20C}, // R5 1->0
        '{8'd6,  1'b1, A, 1'b0, 32'h210, A, 1'b1, 1'b0, 32'h210}, // R6 hold-low
        '{8'd8,  1'b1, A, 1'b1, 32'h300, A, 1'b1, 1'b0, 32'h300}, // R8 0->1 still NT
        '{8'd8,  1'b1, A, 1'b1, 32'h304, A, 1'b1, 1'b1, 32'h304}, // R8 1->2 taken
        '{8'd5,  1'b1, A, 1'b1, 32'h308, A, 1'b1, 1'b1, 32'h308}, // R5 2->3
        '{8'd6,  1'b1, A, 1'b1, 32'h30C, A, 1'b1, 1'b1, 32'h30C}, // R6 hold-high
        '{8'd6,  1'b1, A, 1'b0, 32'h310, A, 1'b1, 1'b1, 32'h310}, // R6 3->2 (no wrap)
        '{8'd10, 1'b1, B, 1'b0, 32'h400, A, 1'b1, 1'b1, 32'h310}, // R10 NT alias ignored
        '{8'd10, 1'b1, B, 1'b1, 32'h500, A, 1'b0, 1'b0, 32'h0},   // R10 taken alias evicts
        '{8'd3,  1'b0, A, 1'b0, 32'h0,   B, 1'b1, 1'b1, 32'h500}, // R3 alias now resident
        '{8'd3,  1'b1, C, 1'b1, 32'h600, C, 1'b1, 1'b1, 32'h600}, // R3 other slot
        '{8'd9,  1'b1, C, 1'b0, 32'h604, C, 1'b1, 1'b1, 32'h604}, // R9 target rewrite
        '{8'd9,  1'b1, C, 1'b0, 32'h608, C, 1'b1, 1'b0, 32'h608}, // R9 target rewrite
        '{8'd2,  1'b0, A, 1'b0, 32'h0,   A, 1'b0, 1'b0, 32'h0}    // R2 miss outputs
    };

    task automatic check(input string tag, input logic eh, input logic et, input logic [AW-1:0] eg);
        n_checks++;
        if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b taken=%0b target=%h, expected hit=%0b taken=%0b target=%h",
                     tag, lk_hit, lk_taken, lk_target, eh, et, eg);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        up_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();

        // R1: empty after reset
        lk_addr = A;
        #2 check("R1 reset, lookup A", 1'b0, 1'b0, '0);

        // vector walk: drive at negedge, sample 2 ns after the writing edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            up_en     = VECS[i].en;
            up_addr   = VECS[i].addr;
            up_taken  = VECS[i].tk;
            up_target = VECS[i].tgt;
            lk_addr   = VECS[i].lk;
            @(posedge clk);
            #2;
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  VECS[i].e_hit, VECS[i].e_tk, VECS[i].e_tgt);
            @(negedge clk);
            up_en = 1'b0;
        end

        // R11: same-cycle collision returns the old contents (A currently evicted)
        @(negedge clk);
        up_en = 1'b1; up_addr = A; up_taken = 1'b1; up_target = 32'h700;
        lk_addr = A;
        #2 check("R11 collision sees old", 1'b0, 1'b0, '0);
        @(posedge clk);
        #2 check("R11 after edge", 1'b1, 1'b1, 32'h700);
        @(negedge clk);
        up_en = 1'b0;

        // R1: reset in mid-run empties the populated table
        do_reset();
        lk_addr = A;
        #2 check("R1 mid-run reset A", 1'b0, 1'b0, '0);
        lk_addr = C;
        #2 check("R1 mid-run reset C", 1'b0, 1'b0, '0);

        // R10: offset bits do not affect indexing or tag
        @(negedge clk);
        up_en = 1'b1; up_addr = C; up_taken = 1'b1; up_target = 32'h800;
        lk_addr = C | 32'h3;
        @(posedge clk);
        #2 check("R10 offset bits ignored", 1'b1, 1'b1, 32'h800);
        @(negedge clk);
        up_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule